// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block joins two processors, called side A and side B, through a small set of shared registers. Each side owns a simple synchronous register port. It has a request strobe, a write enable, a byte address, write data and registered read data, and also one interrupt line. Four word channels run in each direction. A word that one side writes into its transmit slot for channel n is held until the other side reads it from its receive slot for channel n. Full and empty flags on both sides track where each word is.

Besides data words, each side can ring four doorbells towards its peer. A doorbell request stays raised until the peer acknowledges it by clearing the matching pending flag. The sender can therefore poll its own control register to learn that the peer has seen the doorbell. Every flag has its own enable, and the interrupt line of a side is the OR of all enabled flags. Either side can start a unit reset. The reset clears both sides together and reports progress through a busy flag.

Software uses the block by polling status or by taking interrupts. It writes a word or rings a doorbell, and it reads or acknowledges on the far side.

Top module: `ipc_msg_unit`

## Requirements
- R1: After the synchronous reset, each side's status reads 0x00F0_0000, which means all four transmit-empty flags are set and nothing else is. Each control register reads 0 and both interrupt lines are low.
- R2: Each side has four registers at each of the following locations. Transmit register n is at byte offset 4·n. Receive register n is at 0x10+4·n. Status is at 0x20 and control is at 0x24. Read data appears on the read-data port one cycle after the request. A word written to one side's transmit register n is returned by the other side's receive register n. Reads of transmit registers and of unmapped offsets return 0.
- R3: Writing transmit register n clears the writer's transmit-empty flag (status bit 20+(3−n)) and sets the peer's receive-full flag (status bit 24+(3−n)). Reading receive register n clears that receive-full flag and sets the peer's transmit-empty flag again. Reading an empty receive register returns 0 and changes no flag.
- R4: Writing a transmit register whose channel is already full replaces the held word, and both flags stay in the full state.
- R5: Writing 1 to control bit 16+(3−n) raises doorbell n towards the peer. That doorbell shows as the peer's pending flag at status bit 28+(3−n), and it reads back as 1 in the sender's control bit until the peer writes 1 to that pending bit. After the acknowledgement both bits read 0. Writing 0 to either bit has no effect.
- R6: Control bits 20+(3−n), 24+(3−n) and 28+(3−n) are the transmit, receive and doorbell interrupt enables of channel n. They read back as written. Every other control bit reads 0.
- R7: A side's interrupt line is high when at least one of the following holds: a transmit-empty flag is set together with its enable, a receive-full flag is set together with its enable, or a pending doorbell is set together with its enable. The line follows the flags one cycle later.
- R8: If a flag is set and cleared in the same cycle, the set wins. A peer read coinciding with a new write leaves the channel full with the new word, and a doorbell acknowledge coinciding with a new request leaves the doorbell raised.
- R9: Writing control bit 5 on either side starts a unit reset. Status bit 7 then reads 1 for RST_CYCLES cycles, and writes made during that time are ignored. Afterwards both sides are back in the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | AW | Side A byte address |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data, registered |
| a_irq | output | 1 | Side A interrupt |
| b_req | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | AW | Side B byte address |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data, registered |
| b_irq | output | 1 | Side B interrupt |

## Verification
The assertions check several rules on every cycle. A channel written without a unit reset is full in the next cycle. A channel drained by its reader with no coinciding write is empty. A raised doorbell stays raised until the peer acknowledges it. The interrupt stays low while no enable is set. A reset request always produces the busy state and empties every flag. Only the bench scenarios can show the behaviour visible at the register level. This covers the exact bit placement in the status and control words, the values delivered across the mailbox, overwrite of a full channel, and the same-cycle races between the two ports. It also covers the number of cycles the busy flag is visible and the interrupt values under random mixes of enables and traffic.

// File: rtl/mu_pkg.sv
package mu_pkg;
  // word indices within a side's register window (byte offset / 4)
  localparam int RX_WORD0     = 4;
  localparam int STAT_WORD    = 8;
  localparam int CTRL_WORD    = 9;
  // single-bit controls and status
  localparam int RST_REQ_BIT  = 5;
  localparam int RST_BUSY_BIT = 7;
  // group bases; channel 0 sits at the top of each 4-bit group
  localparam int CH_SLOTS     = 4;
  localparam int GR_BASE      = 16;
  localparam int TE_BASE      = 20;
  localparam int RF_BASE      = 24;
  localparam int GP_BASE      = 28;

  function automatic int mirror(int base, int ch);
    return base + (CH_SLOTS - 1 - ch);
  endfunction
endpackage

// File: rtl/mu_mailbox_bank.sv
module mu_mailbox_bank #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [NCH-1:0] wr_en,
  input  logic [DW-1:0]  wr_word,
  input  logic [NCH-1:0] rd_en,
  input  logic [IW-1:0]  rd_idx,
  output logic [NCH-1:0] full,
  output logic [DW-1:0]  rd_word
);
  logic [DW-1:0] mem [NCH];
  logic [IW-1:0] wr_idx;
  logic          wr_any;

  always_comb begin
    wr_idx = '0;
    for (int n = 0; n < NCH; n++)
      if (wr_en[n]) wr_idx = IW'(n);
    wr_any = (|wr_en) && !clr;
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_any) mem[wr_idx] <= wr_word;
  end

  // an empty slot reads as zero
  assign rd_word = full[rd_idx] ? mem[rd_idx] : '0;

  // write (set) has priority over read (clear)
  always_ff @(posedge clk) begin
    for (int n = 0; n < NCH; n++) begin
      if (rst || clr)    full[n] <= 1'b0;
      else if (wr_en[n]) full[n] <= 1'b1;
      else if (rd_en[n]) full[n] <= 1'b0;
    end
  end

  assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_fill_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en[g] && !clr) |=> full[g]);
    assert_drain_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_en[g] && !wr_en[g] && !clr) |=> !full[g]);
  end
endmodule

// File: rtl/mu_doorbell.sv
module mu_doorbell #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic [NCH-1:0] ring_set,
  input  logic [NCH-1:0] ack_clr,
  output logic [NCH-1:0] ring
);
  always_ff @(posedge clk) begin
    for (int n = 0; n < NCH; n++) begin
      if (rst || clr)       ring[n] <= 1'b0;
      else if (ring_set[n]) ring[n] <= 1'b1;
      else if (ack_clr[n])  ring[n] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_ring_set_R8: assert property (@(posedge clk) disable iff (rst)
      (ring_set[g] && !clr) |=> ring[g]);
    assert_ring_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (ring[g] && !ack_clr[g] && !clr) |=> ring[g]);
  end
endmodule

// File: rtl/mu_reset_seq.sv
module mu_reset_seq #(
  parameter int RST_CYCLES = 4,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(RST_CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CW'(RST_CYCLES - 1)));
endmodule

// File: rtl/mu_side_port.sv
module mu_side_port #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 6,
  localparam int WW = AW - 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           busy,
  input  logic           req,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq,
  output logic [NCH-1:0] tx_wr,
  output logic [DW-1:0]  tx_word,
  input  logic [NCH-1:0] tx_full,
  output logic [NCH-1:0] rx_rd,
  output logic [IW-1:0]  rx_idx,
  input  logic [DW-1:0]  rx_word,
  input  logic [NCH-1:0] rx_full,
  output logic [NCH-1:0] ring_set,
  input  logic [NCH-1:0] ring_out,
  output logic [NCH-1:0] ack_clr,
  input  logic [NCH-1:0] ring_in,
  output logic           rst_req
);
  import mu_pkg::*;

  logic [WW-1:0]  word;
  logic           wr_ok, rd_ok, ctl_wr;
  logic [NCH-1:0] tie, rie, gie;
  logic [DW-1:0]  stat_w, ctrl_w, rd_mux;

  assign word    = addr[AW-1:2];
  assign tx_word = wdata;
  assign rx_idx  = IW'(word - WW'(RX_WORD0));

  // access decode
  always_comb begin
    wr_ok    = req && we && !busy;
    rd_ok    = req && !we;
    tx_wr    = '0;
    rx_rd    = '0;
    ring_set = '0;
    ack_clr  = '0;
    rst_req  = 1'b0;
    ctl_wr   = 1'b0;
    for (int n = 0; n < NCH; n++) begin
      tx_wr[n] = wr_ok && (word == WW'(n));
      rx_rd[n] = rd_ok && !busy && (word == WW'(RX_WORD0 + n));
    end
    if (wr_ok && word == WW'(STAT_WORD))
      for (int n = 0; n < NCH; n++) ack_clr[n] = wdata[mirror(GP_BASE, n)];
    if (wr_ok && word == WW'(CTRL_WORD)) begin
      if (wdata[RST_REQ_BIT]) rst_req = 1'b1;
      else begin
        ctl_wr = 1'b1;
        for (int n = 0; n < NCH; n++) ring_set[n] = wdata[mirror(GR_BASE, n)];
      end
    end
  end

  // status and control views
  always_comb begin
    stat_w = '0;
    ctrl_w = '0;
    stat_w[RST_BUSY_BIT] = busy;
    for (int n = 0; n < NCH; n++) begin
      stat_w[mirror(TE_BASE, n)] = !tx_full[n];
      stat_w[mirror(RF_BASE, n)] = rx_full[n];
      stat_w[mirror(GP_BASE, n)] = ring_in[n];
      ctrl_w[mirror(GR_BASE, n)] = ring_out[n];
      ctrl_w[mirror(TE_BASE, n)] = tie[n];
      ctrl_w[mirror(RF_BASE, n)] = rie[n];
      ctrl_w[mirror(GP_BASE, n)] = gie[n];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (word == WW'(STAT_WORD))      rd_mux = stat_w;
    else if (word == WW'(CTRL_WORD)) rd_mux = ctrl_w;
    else if (word >= WW'(RX_WORD0) && word < WW'(RX_WORD0 + NCH)) rd_mux = rx_word;
  end

  // interrupt enables
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tie <= '0;
      rie <= '0;
      gie <= '0;
    end else if (ctl_wr) begin
      for (int n = 0; n < NCH; n++) begin
        tie[n] <= wdata[mirror(TE_BASE, n)];
        rie[n] <= wdata[mirror(RF_BASE, n)];
        gie[n] <= wdata[mirror(GP_BASE, n)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_ok) rdata <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) irq <= 1'b0;
    else irq <= |((~tx_full & tie) | (rx_full & rie) | (ring_in & gie));
  end

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ((tie | rie | gie) == '0) |=> !irq);
endmodule

// File: rtl/ipc_msg_unit.sv
module ipc_msg_unit #(
  parameter int NCH        = 4,
  parameter int DW         = 32,
  parameter int AW         = 6,
  parameter int RST_CYCLES = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  logic           busy, clr, a_rst_req, b_rst_req;
  logic [NCH-1:0] a_tx_wr, b_tx_wr, a_rx_rd, b_rx_rd;
  logic [DW-1:0]  a_tx_word, b_tx_word, ab_word, ba_word;
  logic [IW-1:0]  a_rx_idx, b_rx_idx;
  logic [NCH-1:0] ab_full, ba_full;
  logic [NCH-1:0] a_ring_set, b_ring_set, a_ack, b_ack, ab_ring, ba_ring;

  // request cycle clears too, so the next read already sees the reset state
  assign clr = busy | a_rst_req | b_rst_req;

  mu_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .start(a_rst_req | b_rst_req), .busy(busy));

  mu_mailbox_bank #(.NCH(NCH), .DW(DW)) u_bank_ab (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(a_tx_wr), .wr_word(a_tx_word),
    .rd_en(b_rx_rd), .rd_idx(b_rx_idx),
    .full(ab_full), .rd_word(ab_word));

  mu_mailbox_bank #(.NCH(NCH), .DW(DW)) u_bank_ba (
    .clk(clk), .rst(rst), .clr(clr),
    .wr_en(b_tx_wr), .wr_word(b_tx_word),
    .rd_en(a_rx_rd), .rd_idx(a_rx_idx),
    .full(ba_full), .rd_word(ba_word));

  mu_doorbell #(.NCH(NCH)) u_db_ab (
    .clk(clk), .rst(rst), .clr(clr),
    .ring_set(a_ring_set), .ack_clr(b_ack), .ring(ab_ring));

  mu_doorbell #(.NCH(NCH)) u_db_ba (
    .clk(clk), .rst(rst), .clr(clr),
    .ring_set(b_ring_set), .ack_clr(a_ack), .ring(ba_ring));

  mu_side_port #(.NCH(NCH), .DW(DW), .AW(AW)) u_port_a (
    .clk(clk), .rst(rst), .clr(clr), .busy(busy),
    .req(a_req), .we(a_we), .addr(a_addr), .wdata(a_wdata),
    .rdata(a_rdata), .irq(a_irq),
    .tx_wr(a_tx_wr), .tx_word(a_tx_word), .tx_full(ab_full),
    .rx_rd(a_rx_rd), .rx_idx(a_rx_idx), .rx_word(ba_word), .rx_full(ba_full),
    .ring_set(a_ring_set), .ring_out(ab_ring),
    .ack_clr(a_ack), .ring_in(ba_ring),
    .rst_req(a_rst_req));

  mu_side_port #(.NCH(NCH), .DW(DW), .AW(AW)) u_port_b (
    .clk(clk), .rst(rst), .clr(clr), .busy(busy),
    .req(b_req), .we(b_we), .addr(b_addr), .wdata(b_wdata),
    .rdata(b_rdata), .irq(b_irq),
    .tx_wr(b_tx_wr), .tx_word(b_tx_word), .tx_full(ba_full),
    .rx_rd(b_rx_rd), .rx_idx(b_rx_idx), .rx_word(ab_word), .rx_full(ab_full),
    .ring_set(b_ring_set), .ring_out(ba_ring),
    .ack_clr(b_ack), .ring_in(ab_ring),
    .rst_req(b_rst_req));

  assert_unit_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ab_full == '0 && ba_full == '0 && ab_ring == '0 && ba_ring == '0));
endmodule

// File: tb/ipc_msg_unit_tb_top.sv
module ipc_msg_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int RST_CYCLES = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic        a_irq, b_irq;

  ipc_msg_unit #(.NCH(NCH), .DW(32), .AW(6), .RST_CYCLES(RST_CYCLES)) dut_i (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq));

  int checks = 0, errors = 0;
  bit done = 0;

  // model: index [sender side][channel] for mailbox and doorbells
  logic [31:0] m_data [2][4];
  bit          m_full [2][4];
  bit          m_db   [2][4];
  bit          m_tie  [2][4];
  bit          m_rie  [2][4];
  bit          m_gie  [2][4];

  function automatic int mb(int base, int ch);
    return base + 3 - ch;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 2; s++)
      for (int n = 0; n < 4; n++) begin
        m_full[s][n] = 0; m_db[s][n] = 0;
        m_tie[s][n] = 0; m_rie[s][n] = 0; m_gie[s][n] = 0;
      end
  endtask

  function automatic logic [31:0] exp_rd(int s, int w);
    logic [31:0] v = '0;
    if (w >= 4 && w < 8) begin
      if (m_full[1-s][w-4]) v = m_data[1-s][w-4];
    end else if (w == 8) begin
      for (int n = 0; n < 4; n++) begin
        v[mb(20, n)] = !m_full[s][n];
        v[mb(24, n)] = m_full[1-s][n];
        v[mb(28, n)] = m_db[1-s][n];
      end
    end else if (w == 9) begin
      for (int n = 0; n < 4; n++) begin
        v[mb(16, n)] = m_db[s][n];
        v[mb(20, n)] = m_tie[s][n];
        v[mb(24, n)] = m_rie[s][n];
        v[mb(28, n)] = m_gie[s][n];
      end
    end
    return v;
  endfunction

  function automatic logic exp_irq(int s);
    logic r = 0;
    for (int n = 0; n < 4; n++)
      r |= (!m_full[s][n] && m_tie[s][n]) || (m_full[1-s][n] && m_rie[s][n]) ||
           (m_db[1-s][n] && m_gie[s][n]);
    return r;
  endfunction

  task automatic model_apply(int s, bit we, int w, logic [31:0] wd);
    if (we) begin
      if (w < 4) begin
        m_data[s][w] = wd; m_full[s][w] = 1;
      end else if (w == 8) begin
        for (int n = 0; n < 4; n++) if (wd[mb(28, n)]) m_db[1-s][n] = 0;
      end else if (w == 9) begin
        for (int n = 0; n < 4; n++) begin
          m_tie[s][n] = wd[mb(20, n)];
          m_rie[s][n] = wd[mb(24, n)];
          m_gie[s][n] = wd[mb(28, n)];
          if (wd[mb(16, n)]) m_db[s][n] = 1;
        end
      end
    end else if (w >= 4 && w < 8) begin
      m_full[1-s][w-4] = 0;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(int s, bit we, logic [5:0] ad, logic [31:0] wd);
    if (s == 0) begin a_req = 1; a_we = we; a_addr = ad; a_wdata = wd; end
    else        begin b_req = 1; b_we = we; b_addr = ad; b_wdata = wd; end
  endtask

  task automatic access(int s, bit we, logic [5:0] ad, logic [31:0] wd,
                        output logic [31:0] rd);
    drive(s, we, ad, wd);
    @(negedge clk);
    rd = (s == 0) ? a_rdata : b_rdata;
    a_req = 0; b_req = 0;
  endtask

  task automatic op(int s, bit we, logic [5:0] ad, logic [31:0] wd, string tag,
                    output logic [31:0] rd);
    logic [31:0] e;
    e = exp_rd(s, int'(ad[5:2]));
    access(s, we, ad, wd, rd);
    if (!we) check(tag, rd, e);
    model_apply(s, we, int'(ad[5:2]), wd);
  endtask

  task automatic check_irq(string tag);
    @(negedge clk);
    check({tag, " irq A"}, {31'b0, a_irq}, {31'b0, exp_irq(0)});
    check({tag, " irq B"}, {31'b0, b_irq}, {31'b0, exp_irq(1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    int busy_reads;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    check_irq("R1");
    op(0, 0, 6'h20, 0, "R1 status A", rd); check("R1 status A lit", rd, 32'h00F0_0000);
    op(1, 0, 6'h20, 0, "R1 status B", rd); check("R1 status B lit", rd, 32'h00F0_0000);
    op(0, 0, 6'h24, 0, "R1 control A", rd); check("R1 control A lit", rd, 32'h0);
    op(1, 0, 6'h24, 0, "R1 control B", rd); check("R1 control B lit", rd, 32'h0);

    // R2 / R3: word A->B on channel 0, flag placement
    op(0, 1, 6'h00, 32'h1111_0000, "R3", rd);
    op(1, 0, 6'h20, 0, "R3 status B", rd); check("R3 rf ch0 bit27", rd, 32'h08F0_0000);
    op(0, 0, 6'h20, 0, "R3 status A", rd); check("R3 te ch0 bit23", rd, 32'h0070_0000);
    op(1, 0, 6'h10, 0, "R2 rx B ch0", rd); check("R2 rx B ch0 lit", rd, 32'h1111_0000);
    op(0, 0, 6'h20, 0, "R3 status A drained", rd); check("R3 te back", rd, 32'h00F0_0000);
    op(1, 0, 6'h20, 0, "R3 status B drained", rd); check("R3 rf clear", rd, 32'h00F0_0000);
    // R2: B->A on channel 3, tx read returns 0
    op(1, 1, 6'h0C, 32'h2222_0003, "R2", rd);
    op(1, 0, 6'h0C, 0, "R2 tx read zero", rd); check("R2 tx read lit", rd, 32'h0);
    op(0, 0, 6'h1C, 0, "R2 rx A ch3", rd); check("R2 rx A ch3 lit", rd, 32'h2222_0003);

    // R4: overwrite a full channel
    op(0, 1, 6'h08, 32'hAAAA_0001, "R4", rd);
    op(0, 1, 6'h08, 32'hBBBB_0002, "R4", rd);
    op(0, 0, 6'h20, 0, "R4 status A full", rd); check("R4 te ch2 low", rd, 32'h00D0_0000);
    op(1, 0, 6'h18, 0, "R4 rx B ch2", rd); check("R4 newest word", rd, 32'hBBBB_0002);
    op(1, 0, 6'h18, 0, "R3 empty read", rd); check("R3 empty read lit", rd, 32'h0);
    op(0, 0, 6'h20, 0, "R3 status after empty read", rd); check("R3 no change", rd, 32'h00F0_0000);

    // R5: doorbell handshake, A->B channel 0
    op(0, 1, 6'h24, 32'h0008_0000, "R5", rd);
    op(1, 0, 6'h20, 0, "R5 pending B", rd); check("R5 gip ch0 bit31", rd, 32'h80F0_0000);
    op(0, 0, 6'h24, 0, "R5 request A", rd); check("R5 gir ch0 bit19", rd, 32'h0008_0000);
    op(0, 1, 6'h24, 32'h0, "R5", rd);
    op(0, 0, 6'h24, 0, "R5 zero gir write", rd); check("R5 held after 0", rd, 32'h0008_0000);
    op(1, 1, 6'h20, 32'h0, "R5", rd);
    op(0, 0, 6'h24, 0, "R5 zero ack write", rd); check("R5 held after ack 0", rd, 32'h0008_0000);
    op(1, 1, 6'h20, 32'h8000_0000, "R5", rd);
    op(0, 0, 6'h24, 0, "R5 acked", rd); check("R5 gir dropped", rd, 32'h0);
    op(1, 0, 6'h20, 0, "R5 pending gone", rd); check("R5 gip cleared", rd, 32'h00F0_0000);
    // B->A channel 3
    op(1, 1, 6'h24, 32'h0001_0000, "R5", rd);
    op(0, 0, 6'h20, 0, "R5 pending A ch3", rd); check("R5 gip ch3 bit28", rd, 32'h10F0_0000);
    op(0, 1, 6'h20, 32'h1000_0000, "R5", rd);
    op(1, 0, 6'h24, 0, "R5 B acked", rd); check("R5 gir ch3 dropped", rd, 32'h0);

    // R6 / R7: enables read back, irq from tx-empty
    op(0, 1, 6'h24, 32'hFFF0_FFDF, "R6", rd);
    op(0, 0, 6'h24, 0, "R6 control A", rd); check("R6 enables only", rd, 32'hFFF0_0000);
    check_irq("R7");
    check("R7 irq A high", {31'b0, a_irq}, 32'h1);
    op(0, 1, 6'h24, 32'h0, "R6", rd);
    check_irq("R7");
    check("R7 irq A low", {31'b0, a_irq}, 32'h0);

    // R8: write and peer read in the same cycle
    op(0, 1, 6'h04, 32'hC0DE_0001, "R8", rd);
    drive(0, 1, 6'h04, 32'hC0DE_0002);
    drive(1, 0, 6'h14, 0);
    @(negedge clk);
    rd2 = b_rdata;
    a_req = 0; b_req = 0;
    check("R8 old word read", rd2, 32'hC0DE_0001);
    m_data[0][1] = 32'hC0DE_0002; m_full[0][1] = 1;
    op(1, 0, 6'h20, 0, "R8 still full", rd); check("R8 rf ch1 bit26", rd, 32'h04F0_0000);
    op(1, 0, 6'h14, 0, "R8 new word", rd); check("R8 new word lit", rd, 32'hC0DE_0002);
    // R8: doorbell request and acknowledge in the same cycle
    op(0, 1, 6'h24, 32'h0008_0000, "R8", rd);
    drive(0, 1, 6'h24, 32'h0008_0000);
    drive(1, 1, 6'h20, 32'h8000_0000);
    @(negedge clk);
    a_req = 0; b_req = 0;
    op(1, 0, 6'h20, 0, "R8 doorbell kept", rd); check("R8 gip kept", rd, 32'h80F0_0000);
    op(1, 1, 6'h20, 32'h8000_0000, "R8", rd);

    // R9: unit reset from side B
    op(1, 1, 6'h24, 32'h0F00_0000, "R9", rd);
    op(0, 1, 6'h0C, 32'h3333_0003, "R9", rd);
    check_irq("R7");
    check("R7 irq B rx", {31'b0, b_irq}, 32'h1);
    access(1, 1, 6'h24, 32'h0000_0020, rd);
    access(0, 1, 6'h00, 32'h5555_5555, rd);
    busy_reads = 0;
    for (int i = 0; i < RST_CYCLES + 3; i++) begin
      access(0, 0, 6'h20, 0, rd);
      if (i == 0) check("R9 busy status", rd, 32'h00F0_0080);
      if (!rd[7]) break;
      busy_reads++;
    end
    check("R9 busy length", busy_reads, RST_CYCLES - 1);
    check("R9 status A after", rd, 32'h00F0_0000);
    model_reset();
    op(1, 0, 6'h20, 0, "R9 status B after", rd); check("R9 write ignored", rd, 32'h00F0_0000);
    op(1, 0, 6'h24, 0, "R9 control B after", rd); check("R9 control cleared", rd, 32'h0);
    op(1, 0, 6'h10, 0, "R9 rx empty", rd); check("R9 rx empty lit", rd, 32'h0);
    check_irq("R9");

    // random traffic against the model
    for (int it = 0; it < 400; it++) begin
      int s, k, ch;
      logic [31:0] wd;
      s  = int'($urandom % 2);
      k  = int'($urandom % 6);
      ch = int'($urandom % 4);
      wd = $urandom;
      case (k)
        0: op(s, 1, 6'(ch * 4), wd, "R2", rd);
        1: op(s, 0, 6'(16 + ch * 4), 0, "R3 random rx", rd);
        2: op(s, 0, 6'h20, 0, "R3 random status", rd);
        3: op(s, 1, 6'h24, wd & ~32'h20, "R6", rd);
        4: op(s, 1, 6'h20, wd, "R5", rd);
        default: op(s, 0, 6'h24, 0, "R6 random control", rd);
      endcase
      check_irq("R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule